// File: doc/BRIEF.md
# Bit-Split Rule Module Intersector

This block scans a byte stream for a set of up to sixteen patterns by running four small automata side by side. Every byte is cut into four 2-bit symbols, and each symbol drives its own tile. A tile is a table-driven state machine whose alphabet has only four letters. Each state of a tile carries a 16-bit partial match vector. A pattern bit set in that vector means "as far as this tile's two bits can tell, pattern p may have just ended".

The four tiles step together on every valid byte. The block reports a pattern only when all four tiles raise its bit, so the full match vector is the bitwise AND of the four partial vectors. Patterns are found at any byte offset, and patterns that overlap or end on the same byte are reported together. The tile tables are loaded through a single write port that picks the tile with a 2-bit select. Reset puts every tile back in state 0 so that scanning can restart at a packet boundary, and the loaded tables survive the reset.

Top module: `bsm_rule_module`

## Requirements
- R1: Tile t receives bits [2t+1:2t] of `in_byte`: tile 0 gets bits 1:0, tile 1 gets bits 3:2, tile 2 gets bits 5:4 and tile 3 gets bits 7:6.
- R2: On a clock edge with `in_valid` high, each tile moves to the next-state pointer that its table holds for its current state and its own 2-bit symbol. All four tiles step on the same edge.
- R3: `match_vec` is the bitwise AND of the partial match vectors of the four states just entered, so a pattern bit is 1 only if every tile flags it.
- R4: `match_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `match_vec` in that cycle belongs to that byte (one cycle of latency).
- R5: While `match_valid` is low, `match_vec` is zero. Cycles with `in_valid` low leave every tile state unchanged, so a pattern that is split by idle cycles is still found.
- R6: A pattern is reported on the byte that ends it, whatever its offset in the stream. Patterns ending on the same byte are all reported in the same vector.
- R7: A write with `cfg_we` high loads entry `cfg_state` of the tile that `cfg_tile` selects. The entry is the next-state pointers `cfg_next`, with the pointer for symbol k at bits [k*SW +: SW] where SW = clog2(STATES), and the partial vector `cfg_pmv`. The entry is used from the next cycle on, and no other tile changes.
- R8: Reset (`rst` high, synchronous) returns all tiles to state 0 and clears `match_valid`. It does not clear the tables.
- R9: With the tables built for {he, she, his, hers} as bits 0 to 3, the stream "hxhe" reports bit 0 ("he") on its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of tile states and output valid |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_tile | input | 2 | Tile chosen by the write |
| cfg_state | input | clog2(STATES) | Table entry (state index) written |
| cfg_next | input | 4*clog2(STATES) | Next-state pointers, one per 2-bit symbol |
| cfg_pmv | input | PATTERNS | Partial match vector of the entry |
| match_valid | output | 1 | `match_vec` is valid |
| match_vec | output | PATTERNS | Patterns that ended on the byte accepted one cycle earlier |

## Verification
On every cycle the assertions check the one-cycle tie between `in_valid` and `match_valid`, the zero vector while the output is not valid, the frozen tile state on idle cycles, the state after reset, and that a table write is stored where it was aimed. Only the bench scenarios can show that the tables really detect the patterns: the exact vectors for {he, she, his, hers} over aligned, overlapping and idle-split streams, and that the four tiles vote by AND. The bench shows the AND vote and the bit routing by clearing one flag in a single tile's entry. It then checks that the match disappears and returns after the entry is restored.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    localparam int BYTE_W = 8;
    localparam int SYM_W  = 2;
    localparam int TILES  = BYTE_W / SYM_W;
    localparam int BRANCH = 1 << SYM_W;
    localparam int TSEL_W = $clog2(TILES);

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [TSEL_W-1:0] tile_sel_t;

endpackage

// File: rtl/bsm_byte_split.sv
module bsm_byte_split
    import bsm_pkg::*;
(
    input  logic [BYTE_W-1:0]       byte_i,
    output logic [TILES*SYM_W-1:0]  syms_o
);

    // Field t of the byte feeds tile t (R1).
    for (genvar t = 0; t < TILES; t++) begin : g_field
        assign syms_o[t*SYM_W +: SYM_W] = byte_i[t*SYM_W +: SYM_W];
    end

endmodule

// File: rtl/bsm_tile.sv
module bsm_tile
    import bsm_pkg::*;
#(
    parameter int STATES   = 16,
    parameter int PATTERNS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step_i,
    input  sym_t                        sym_i,
    input  logic                        wr_en_i,
    input  logic [$clog2(STATES)-1:0]   wr_addr_i,
    input  logic [BRANCH*$clog2(STATES)-1:0] wr_next_i,
    input  logic [PATTERNS-1:0]         wr_pmv_i,
    output logic [PATTERNS-1:0]         pmv_o
);

    localparam int SW     = $clog2(STATES);
    localparam int NEXT_W = BRANCH * SW;

    typedef struct packed {
        logic [SW-1:0] state;
    } tile_reg_t;

    tile_reg_t          reg_d, reg_q;
    logic [NEXT_W-1:0]  next_mem [STATES];
    logic [PATTERNS-1:0] pmv_mem [STATES];
    logic [NEXT_W-1:0]  row_d;

    // Next value: follow the pointer for the current symbol when stepping.
    always_comb begin
        reg_d = reg_q;
        row_d = next_mem[reg_q.state];
        if (step_i) begin
            reg_d.state = row_d[int'(sym_i) * SW +: SW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    // Table storage keeps its contents through reset (R8).
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            next_mem[wr_addr_i] <= wr_next_i;
            pmv_mem[wr_addr_i]  <= wr_pmv_i;
        end
    end

    assign pmv_o = pmv_mem[reg_q.state];

    // R5: no step, no move.
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(reg_q.state));

    // R7: a write lands in the addressed entry.
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (pmv_mem[$past(wr_addr_i)] == $past(wr_pmv_i))
                    && (next_mem[$past(wr_addr_i)] == $past(wr_next_i)));

    // R8: state 0 right after reset.
    a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_q.state == '0));

endmodule

// File: rtl/bsm_and_combine.sv
module bsm_and_combine
    import bsm_pkg::*;
#(
    parameter int PATTERNS = 16
) (
    input  logic [TILES*PATTERNS-1:0] pmv_flat_i,
    input  logic                      gate_i,
    output logic [PATTERNS-1:0]       match_o
);

    logic [PATTERNS-1:0] acc [TILES+1];

    assign acc[0] = '1;

    // Running AND across the tiles (R3).
    for (genvar t = 0; t < TILES; t++) begin : g_and
        assign acc[t+1] = acc[t] & pmv_flat_i[t*PATTERNS +: PATTERNS];
    end

    assign match_o = gate_i ? acc[TILES] : '0;

endmodule

// File: rtl/bsm_rule_module.sv
module bsm_rule_module
    import bsm_pkg::*;
#(
    parameter int STATES   = 16,
    parameter int PATTERNS = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [7:0]                       in_byte,
    input  logic                             cfg_we,
    input  logic [1:0]                       cfg_tile,
    input  logic [$clog2(STATES)-1:0]        cfg_state,
    input  logic [BRANCH*$clog2(STATES)-1:0] cfg_next,
    input  logic [PATTERNS-1:0]              cfg_pmv,
    output logic                             match_valid,
    output logic [PATTERNS-1:0]              match_vec
);

    typedef struct packed {
        logic valid;
    } top_reg_t;

    top_reg_t                   reg_d, reg_q;
    logic [TILES*SYM_W-1:0]     syms;
    logic [TILES*PATTERNS-1:0]  pmv_flat;
    tile_sel_t                  sel;

    assign sel = tile_sel_t'(cfg_tile);

    bsm_byte_split u_split (
        .byte_i (in_byte),
        .syms_o (syms)
    );

    for (genvar t = 0; t < TILES; t++) begin : g_tile
        logic wr_hit;
        assign wr_hit = cfg_we && (sel == tile_sel_t'(t));

        bsm_tile #(
            .STATES   (STATES),
            .PATTERNS (PATTERNS)
        ) u_tile (
            .clk       (clk),
            .rst       (rst),
            .step_i    (in_valid),
            .sym_i     (syms[t*SYM_W +: SYM_W]),
            .wr_en_i   (wr_hit),
            .wr_addr_i (cfg_state),
            .wr_next_i (cfg_next),
            .wr_pmv_i  (cfg_pmv),
            .pmv_o     (pmv_flat[t*PATTERNS +: PATTERNS])
        );
    end

    always_comb begin
        reg_d       = reg_q;
        reg_d.valid = in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    bsm_and_combine #(
        .PATTERNS (PATTERNS)
    ) u_combine (
        .pmv_flat_i (pmv_flat),
        .gate_i     (reg_q.valid),
        .match_o    (match_vec)
    );

    assign match_valid = reg_q.valid;

    // R4: output valid trails input valid by one cycle.
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> match_valid);

    a_r4_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !match_valid);

    // R5: quiet vector when not valid.
    a_r5_quiet_vector: assert property (@(posedge clk) disable iff (rst)
        !match_valid |-> (match_vec == '0));

    // R8: valid cleared by reset.
    a_r8_reset_valid: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !match_valid);

endmodule

// File: tb/tb_bsm_rule_module.sv
module tb_bsm_rule_module;

    localparam int ST  = 256;
    localparam int SW  = 8;
    localparam int PW  = 16;

    // Patterns, newest character in the low byte: he, she, his, hers.
    localparam logic [31:0] PAT [4] = '{32'h00006865, 32'h00736865,
                                        32'h00686973, 32'h68657273};
    localparam int PLEN [4] = '{2, 3, 3, 4};

    // Walk table: {byte, expected vector} for "hxhersshehis" then "hhe".
    localparam logic [23:0] WALK [15] = '{
        {"h", 16'h0000}, {"x", 16'h0000}, {"h", 16'h0000}, {"e", 16'h0001},
        {"r", 16'h0000}, {"s", 16'h0008}, {"s", 16'h0000}, {"h", 16'h0000},
        {"e", 16'h0003}, {"h", 16'h0000}, {"i", 16'h0000}, {"s", 16'h0004},
        {"h", 16'h0000}, {"h", 16'h0000}, {"e", 16'h0001}};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [7:0]     in_byte = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_tile = '0;
    logic [SW-1:0]  cfg_state = '0;
    logic [4*SW-1:0] cfg_next = '0;
    logic [PW-1:0]  cfg_pmv = '0;
    logic           match_valid;
    logic [PW-1:0]  match_vec;

    int checks = 0;
    int errors = 0;
    logic [31:0]    hist = '0;
    int             cnt = 0;
    bit             pend_valid = 1'b0;
    logic [PW-1:0]  pend_exp = '0;
    string          pend_tag = "";

    always #4 clk = ~clk;

    bsm_rule_module #(.STATES(ST), .PATTERNS(PW)) dut (
        .clk, .rst, .in_valid, .in_byte, .cfg_we, .cfg_tile, .cfg_state,
        .cfg_next, .cfg_pmv, .match_valid, .match_vec
    );

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] refm(input logic [7:0] b);
        logic [PW-1:0] v = '0;
        hist = {hist[23:0], b};
        cnt++;
        for (int p = 0; p < 4; p++) begin
            bit ok = (cnt >= PLEN[p]);
            for (int j = 0; j < PLEN[p]; j++)
                if (hist[8*j +: 8] != PAT[p][8*j +: 8]) ok = 1'b0;
            v[p] = ok;
        end
        return v;
    endfunction

    function automatic logic [SW-1:0] tile_state(input int t, input logic [31:0] h);
        logic [SW-1:0] s;
        for (int j = 0; j < 4; j++) s[2*j +: 2] = h[8*j + 2*t +: 2];
        return s;
    endfunction

    function automatic logic [PW-1:0] tile_pmv(input int t, input logic [SW-1:0] s);
        logic [PW-1:0] v = '0;
        for (int p = 0; p < 4; p++) begin
            bit ok = 1'b1;
            for (int j = 0; j < PLEN[p]; j++)
                if (s[2*j +: 2] != PAT[p][8*j + 2*t +: 2]) ok = 1'b0;
            v[p] = ok;
        end
        return v;
    endfunction

    function automatic logic [4*SW-1:0] tile_next(input logic [SW-1:0] s);
        logic [4*SW-1:0] n;
        for (int k = 0; k < 4; k++) n[k*SW +: SW] = {s[SW-3:0], 2'(k)};
        return n;
    endfunction

    // One negedge: check the output owed for the previous cycle, then drive.
    task automatic tick(input bit v, input logic [7:0] b, input logic [PW-1:0] exp, input string tag);
        @(negedge clk);
        if (pend_valid) begin
            chk({pend_tag, " R4 valid"}, {15'b0, match_valid}, 16'h0001);
            chk(pend_tag, match_vec, pend_exp);
        end else begin
            chk("R5 idle valid", {15'b0, match_valid}, 16'h0000);
            chk("R5 idle vector", match_vec, 16'h0000);
        end
        in_valid   = v;
        in_byte    = b;
        pend_valid = v;
        pend_exp   = exp;
        pend_tag   = tag;
    endtask

    task automatic cfg_write(input int t, input logic [SW-1:0] s, input logic [PW-1:0] pmv);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_tile  = 2'(t);
        cfg_state = s;
        cfg_next  = tile_next(s);
        cfg_pmv   = pmv;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        pend_valid = 1'b0;
        hist = '0;
        cnt = 0;
    endtask

    task automatic send(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            logic [PW-1:0] e;
            e = refm(s[i]);
            tick(1'b1, s[i], e, tag);
        end
    endtask

    initial begin
        logic [SW-1:0] s1;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {15'b0, match_valid}, 16'h0000);
        chk("R8 reset vector", match_vec, 16'h0000);
        rst = 1'b0;

        for (int t = 0; t < 4; t++)
            for (int s = 0; s < ST; s++)
                cfg_write(t, SW'(s), tile_pmv(t, SW'(s)));

        // Table walk with idle cycles between bytes (R6, R9, R3, R5).
        for (int i = 0; i < 15; i++) begin
            logic [PW-1:0] e;
            e = refm(WALK[i][23:16]);
            tick(1'b1, WALK[i][23:16], WALK[i][15:0], (i == 3) ? "R9 hxhe" : "R6 walk");
            tick(1'b0, 8'h00, 16'h0000, "R5 gap");
        end

        // Back-to-back stream against the reference model (R2, R4, R6).
        send("ushers his she hers", "R2 stream");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");

        // Pattern split by idle cycles (R5).
        send("sh", "R5 split");
        repeat (3) tick(1'b0, 8'h00, 16'h0000, "R5 gap");
        send("e", "R5 split end");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");

        // Reset between bytes clears state but keeps tables (R8).
        send("h", "R8 before reset");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");
        do_reset();
        tick(1'b1, "e", 16'h0000, "R8 state cleared");
        void'(refm("e"));
        send("he", "R8 tables kept");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");

        // Clear the "he" flag in one tile-1 entry only (R1, R3, R7).
        do_reset();
        s1 = tile_state(1, "hxhe");
        cfg_write(1, s1, tile_pmv(1, s1) & ~16'h0001);
        tick(1'b1, "h", 16'h0000, "R7 edit");
        tick(1'b1, "x", 16'h0000, "R7 edit");
        tick(1'b1, "h", 16'h0000, "R7 edit");
        tick(1'b1, "e", 16'h0000, "R1 R3 R7 one tile vetoes");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");
        cfg_write(1, s1, tile_pmv(1, s1));
        tick(1'b1, "h", 16'h0000, "R7 restore");
        tick(1'b1, "x", 16'h0000, "R7 restore");
        tick(1'b1, "h", 16'h0000, "R7 restore");
        tick(1'b1, "e", 16'h0001, "R7 restored match");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");
        tick(1'b0, 8'h00, 16'h0000, "R5 gap");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule